// File: doc/BRIEF.md
# Light Sensor Interrupt Controller

This block sits after a two-channel light measurement path and decides, sample by sample, whether software should be interrupted. Each accepted beat carries one 20-bit result for the clear (broadband) channel and one for the main light channel. A source select picks the channel that is judged. Two judging rules are available. In window mode, a result counts as an event when it falls outside a programmable band. In change mode, a result counts as an event when it differs from the previous judged result by more than a step that doubles with each code value.

Events pass through a run-length filter before they reach the status flag. The filter requires a programmed number of back-to-back events. Once set, the flag is sticky until a read strobe clears it. While the flag is set, the block asks the open-drain interrupt pad to pull low. The band limits are held in the block and are loaded together by a single strobe.

Samples arrive on a valid/ready stream. The block never applies back-pressure: ready rises on the first clock after reset and then stays high. A beat is taken on any edge where valid and ready are both high. When valid is low, the block state does not change.

Top module: `light_irq_ctrl`

## Requirements
- R1: While `cfg_en` is low, no sample can set the status flag. The run counter and the previous-sample history are both cleared.
- R2: In window mode (`cfg_var_mode`=0), a judged sample is an event when it is strictly greater than the upper limit or strictly less than the lower limit. A sample equal to either limit is not an event.
- R3: In change mode (`cfg_var_mode`=1), a judged sample is an event when |current − previous| is strictly greater than 8·2^`cfg_var_code`. The step is 8 for code 0 and 1024 for code 7. The rule applies in both directions of change.
- R4: With persist value P (`cfg_persist`, 0 to 15), the flag is set on the (P+1)-th event in an unbroken run of events. After that, every further event in the same run sets it again.
- R5: Any accepted sample that is not an event, taken while the block is enabled, restarts the run count at zero.
- R6: The flag sets on the clock edge that accepts the qualifying sample, and it is visible in the following cycle. A high `stat_rd` clears the flag at the next edge. If a set and a clear fall on the same edge, the set wins. `irq_pull_low` is high exactly when the flag is high.
- R7: `cfg_src_sel`=2'b00 judges `smp_clear`. Any other value judges `smp_main`.
- R8: The first sample accepted after the block is enabled only loads the history register. In change mode it is never an event.
- R9: After reset, the upper limit is 0x0FFFFF and the lower limit is 0. A high `thr_load` replaces both limits at that edge, and the new limits apply to samples accepted on later edges.
- R10: `smp_ready` is low during reset and high from the first clock after reset. A cycle with `smp_valid` low changes neither the run count nor the history nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Block accepts beats |
| smp_clear | input | 20 | Clear channel result |
| smp_main | input | 20 | Main light channel result |
| cfg_en | input | 1 | Interrupt logic enable |
| cfg_var_mode | input | 1 | 0 window mode, 1 change mode |
| cfg_src_sel | input | 2 | Channel select (00 clear, other main) |
| cfg_persist | input | 4 | Run length minus one |
| cfg_var_code | input | 3 | Change step code |
| thr_load | input | 1 | Load both limits |
| thr_hi_in | input | 20 | Upper limit to load |
| thr_lo_in | input | 20 | Lower limit to load |
| stat_rd | input | 1 | Status read strobe (clear) |
| stat_flag | output | 1 | Sticky interrupt status |
| irq_pull_low | output | 1 | Drive the open-drain request pad low |

## Verification
Most of this block's hidden state shows up only through timing. A run counter that does not restart, or one that is off by one, makes the flag rise one or more accepted samples too early or too late. A stale or wrongly loaded history register turns a quiet change-mode sample into a spurious flag on that same beat, or hides a real one. Wrong limit registers show up on the first sample that lands on or next to a limit. The bench steps a behavioural model every clock and compares the flag, the pad request and ready one cycle after each edge, so any of these faults is seen at the cycle where it first changes the flag.

// File: rtl/light_irq_pkg.sv
package light_irq_pkg;

  typedef enum logic {
    JUDGE_WINDOW = 1'b0,
    JUDGE_CHANGE = 1'b1
  } judge_mode_e;

  typedef enum logic [1:0] {
    SRC_CLEAR = 2'b00,
    SRC_MAIN  = 2'b01
  } src_sel_e;

  localparam int unsigned BASE_STEP = 8;

endpackage

// File: rtl/light_irq_detect.sv
module light_irq_detect
  import light_irq_pkg::*;
#(
  parameter int unsigned W      = 20,
  parameter int unsigned CODE_W = 3
) (
  input  logic [W-1:0]      sample,
  input  logic [W-1:0]      prev,
  input  logic              prev_ok,
  input  logic              mode,
  input  logic [W-1:0]      thr_hi,
  input  logic [W-1:0]      thr_lo,
  input  logic [CODE_W-1:0] code,
  output logic              evt
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  delta;
  logic [SW-1:0] step;
  logic          win_evt;
  logic          chg_evt;

  always_comb begin
    delta   = (sample >= prev) ? (sample - prev) : (prev - sample);
    step    = SW'(BASE_STEP) << code;
    win_evt = (sample > thr_hi) || (sample < thr_lo);
    chg_evt = prev_ok && ({1'b0, delta} > step);
    evt     = (judge_mode_e'(mode) == JUDGE_CHANGE) ? chg_evt : win_evt;
  end

endmodule

// File: rtl/light_irq_persist.sv
module light_irq_persist #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             acc,
  input  logic             evt,
  input  logic [CNT_W-1:0] persist,
  output logic             fire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign fire = en && acc && evt && (cnt_q >= persist);
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (acc) begin
      if (!evt)                  cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/light_irq_status.sv
module light_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic rd,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (fire) flag <= 1'b1;
    else if (rd)   flag <= 1'b0;
  end
endmodule

// File: rtl/light_irq_ctrl.sv
module light_irq_ctrl
  import light_irq_pkg::*;
#(
  parameter int unsigned W          = 20,
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned CNT_W      = 4,
  parameter logic [W-1:0] HI_RESET  = 20'h0FFFFF,
  parameter logic [W-1:0] LO_RESET  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [W-1:0]      smp_clear,
  input  logic [W-1:0]      smp_main,
  input  logic              cfg_en,
  input  logic              cfg_var_mode,
  input  logic [1:0]        cfg_src_sel,
  input  logic [CNT_W-1:0]  cfg_persist,
  input  logic [CODE_W-1:0] cfg_var_code,
  input  logic              thr_load,
  input  logic [W-1:0]      thr_hi_in,
  input  logic [W-1:0]      thr_lo_in,
  input  logic              stat_rd,
  output logic              stat_flag,
  output logic              irq_pull_low
);
  logic         rdy_q;
  logic [W-1:0] hi_q, lo_q;
  logic [W-1:0] prev_q;
  logic         prev_ok_q;
  logic [W-1:0] judged;
  logic         acc_w, evt_w, fire_w;
  logic [CNT_W-1:0] cnt_w;

  assign smp_ready = rdy_q;
  assign acc_w     = smp_valid && rdy_q;
  assign judged    = (src_sel_e'(cfg_src_sel) == SRC_CLEAR) ? smp_clear : smp_main;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RESET;
      lo_q <= LO_RESET;
    end else if (thr_load) begin
      hi_q <= thr_hi_in;
      lo_q <= thr_lo_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (!cfg_en) begin
      prev_ok_q <= 1'b0;
    end else if (acc_w) begin
      prev_q    <= judged;
      prev_ok_q <= 1'b1;
    end
  end

  light_irq_detect #(.W(W), .CODE_W(CODE_W)) u_detect (
    .sample  (judged),
    .prev    (prev_q),
    .prev_ok (prev_ok_q),
    .mode    (cfg_var_mode),
    .thr_hi  (hi_q),
    .thr_lo  (lo_q),
    .code    (cfg_var_code),
    .evt     (evt_w)
  );

  light_irq_persist #(.CNT_W(CNT_W)) u_persist (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_en),
    .acc     (acc_w),
    .evt     (evt_w),
    .persist (cfg_persist),
    .fire    (fire_w),
    .cnt     (cnt_w)
  );

  light_irq_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire_w),
    .rd    (stat_rd),
    .flag  (stat_flag)
  );

  assign irq_pull_low = stat_flag;

endmodule

// File: rtl/light_irq_ctrl_chk.sv
module light_irq_ctrl_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_var_mode,
  input logic             stat_rd,
  input logic             stat_flag,
  input logic             irq_pull_low,
  input logic             smp_ready,
  input logic             acc_w,
  input logic             evt_w,
  input logic             fire_w,
  input logic             prev_ok_q,
  input logic [CNT_W-1:0] cnt_w
);
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !stat_flag) |=> !stat_flag);

  p_fire_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |=> stat_flag);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !fire_w) |=> !stat_flag);

  p_pad_tracks_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull_low == stat_flag);

  p_fire_needs_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire_w |-> (acc_w && evt_w));

  p_quiet_sample_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && acc_w && !evt_w) |=> (cnt_w == '0));

  p_first_change_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_var_mode && acc_w && !prev_ok_q) |-> !evt_w);

  p_ready_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> smp_ready);
endmodule

bind light_irq_ctrl light_irq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .cfg_var_mode (cfg_var_mode),
  .stat_rd      (stat_rd),
  .stat_flag    (stat_flag),
  .irq_pull_low (irq_pull_low),
  .smp_ready    (smp_ready),
  .acc_w        (acc_w),
  .evt_w        (evt_w),
  .fire_w       (fire_w),
  .prev_ok_q    (prev_ok_q),
  .cnt_w        (cnt_w)
);

// File: tb/light_irq_ctrl_tb.sv
module light_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [19:0] smp_clear = '0, smp_main = '0;
  logic        cfg_en = 1'b0, cfg_var_mode = 1'b0;
  logic [1:0]  cfg_src_sel = 2'b01;
  logic [3:0]  cfg_persist = '0;
  logic [2:0]  cfg_var_code = '0;
  logic        thr_load = 1'b0;
  logic [19:0] thr_hi_in = '0, thr_lo_in = '0;
  logic        stat_rd = 1'b0;
  logic        stat_flag, irq_pull_low;

  always #4 clk = ~clk;

  light_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_clear(smp_clear), .smp_main(smp_main), .cfg_en(cfg_en),
    .cfg_var_mode(cfg_var_mode), .cfg_src_sel(cfg_src_sel),
    .cfg_persist(cfg_persist), .cfg_var_code(cfg_var_code),
    .thr_load(thr_load), .thr_hi_in(thr_hi_in), .thr_lo_in(thr_lo_in),
    .stat_rd(stat_rd), .stat_flag(stat_flag), .irq_pull_low(irq_pull_low)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  // behavioural reference state
  int  m_hi = 'h0FFFFF, m_lo = 0, m_prev = 0, m_cnt = 0;
  bit  m_prev_ok = 0, m_flag = 0, m_ready = 0;

  function automatic void model_edge();
    int s, d, stp;
    bit acc, evt, fire;
    acc  = smp_valid && m_ready;
    fire = 0;
    if (!cfg_en) begin
      m_cnt = 0;
      m_prev_ok = 0;
    end else if (acc) begin
      s = (cfg_src_sel == 2'b00) ? int'(smp_clear) : int'(smp_main);
      d = (s > m_prev) ? s - m_prev : m_prev - s;
      stp = 8 * (1 << cfg_var_code);
      if (cfg_var_mode) evt = m_prev_ok && (d > stp);
      else              evt = (s > m_hi) || (s < m_lo);
      fire = evt && (m_cnt >= int'(cfg_persist));
      m_cnt = evt ? ((m_cnt < 15) ? m_cnt + 1 : 15) : 0;
      m_prev = s;
      m_prev_ok = 1;
    end
    if (thr_load) begin
      m_hi = int'(thr_hi_in);
      m_lo = int'(thr_lo_in);
    end
    if (fire)         m_flag = 1;
    else if (stat_rd) m_flag = 0;
    m_ready = 1;
  endfunction

  task automatic compare();
    checks++;
    if (stat_flag !== m_flag || irq_pull_low !== m_flag || smp_ready !== m_ready) begin
      errors++;
      $display("FAIL %s t=%0t flag=%b pad=%b ready=%b expected flag=%b pad=%b ready=%b",
               cur_req, $time, stat_flag, irq_pull_low, smp_ready, m_flag, m_flag, m_ready);
    end
  endtask

  // one clock: inputs set now, edge, compare at next falling edge
  task automatic step(input bit v, input int clr, input int mn, input bit rd = 0);
    smp_valid = v;
    smp_clear = 20'(clr);
    smp_main  = 20'(mn);
    stat_rd   = rd;
    model_edge();
    @(negedge clk);
    compare();
    smp_valid = 0;
    stat_rd   = 0;
    thr_load  = 0;
  endtask

  task automatic sample(input int mn);
    step(1, 0, mn);
  endtask

  task automatic clear_flag();
    step(0, 0, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    cur_req = "R10";
    repeat (2) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    step(1, 0, 'h0FFFFF);         // R10: not accepted, ready was still low
    step(0, 0, 0);

    // R9: reset limits; full-scale and zero are inside the band
    cur_req = "R9";
    cfg_en = 1;
    sample('h0FFFFF);
    sample(0);

    // R2: window edges are strict
    cur_req = "R2";
    thr_hi_in = 1000; thr_lo_in = 100; thr_load = 1;
    cur_req = "R9";
    step(0, 0, 0);
    cur_req = "R2";
    sample(1000);
    sample(1001);
    cur_req = "R6";
    clear_flag();
    cur_req = "R2";
    sample(100);
    sample(99);
    clear_flag();

    // R10: valid low beat leaves flag alone
    cur_req = "R10";
    step(0, 0, 5000);
    step(0, 0, 5000);

    // R4 / R5: three in a row needed
    cur_req = "R4";
    cfg_persist = 2;
    sample(2000); sample(2000);
    cur_req = "R5";
    sample(500);
    cur_req = "R4";
    sample(2000); sample(2000); sample(2000);
    sample(2000);
    clear_flag();
    cfg_persist = 15;
    for (int i = 0; i < 17; i++) sample(3000);
    clear_flag();
    cfg_persist = 0;

    // R6: set wins over clear on the same edge
    cur_req = "R6";
    sample(5000);
    step(1, 0, 5000, 1);
    clear_flag();

    // R7: channel selection
    cur_req = "R7";
    cfg_src_sel = 2'b00;
    step(1, 5000, 500);
    clear_flag();
    step(1, 500, 5000);
    cfg_src_sel = 2'b01;
    step(1, 5000, 500);
    cfg_src_sel = 2'b11;
    step(1, 500, 5000);
    clear_flag();
    cfg_src_sel = 2'b01;

    // R1: disabled, out-of-band samples do nothing
    cur_req = "R1";
    cfg_en = 0;
    sample(9000); sample(9000); sample(9000);

    // R8 / R3: change mode
    cur_req = "R8";
    cfg_var_mode = 1; cfg_var_code = 0;
    step(0, 0, 0);
    cfg_en = 1;
    sample(90000);
    cur_req = "R3";
    sample(90008);
    sample(90017);
    clear_flag();
    sample(90008);
    clear_flag();
    cfg_var_code = 7;
    sample(91032);
    sample(92057);
    clear_flag();
    sample(91033);
    clear_flag();

    // random traffic against the model
    cur_req = "R2 R3 R4 R5 random";
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 50) == 0) begin
        thr_hi_in = 20'(1000 + $urandom % 200);
        thr_lo_in = 20'(800 + $urandom % 200);
        thr_load = 1;
      end
      if (($urandom % 40) == 0) cfg_var_mode = ~cfg_var_mode;
      if (($urandom % 40) == 0) cfg_persist = 4'($urandom % 4);
      if (($urandom % 60) == 0) cfg_en = ~cfg_en;
      cfg_var_code = 3'($urandom % 3);
      step(($urandom % 4) != 0, 700 + $urandom % 600, 700 + $urandom % 600,
           ($urandom % 6) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule